// File: doc/BRIEF.md
# Serial Instruction Decoder and Channel Register File

This block is the host-side front end of a multi-channel serial-data receiver. A host processor talks to it over a four-wire SPI slave link (chip select, clock, data in, data out). Each transaction opens with an 8-bit instruction. Its upper nibble names a receive channel and its lower nibble names an operation. A data field of 0, 16, 32 or 128 bits follows, and the block moves it into or out of the addressed resource.

The resources are as follows. Each channel has a configuration register with ten stored bits and a 128-bit table of sixteen 8-bit labels. Each channel also has a view of the head word of its receive FIFO, and the block can pop and clear that FIFO. Shared by all channels are a status word that packs every FIFO's empty and full flags, a master-reset strobe, and a 32-bit transmit word with a rate select. The receive logic, the FIFOs themselves and the transmit serializer live outside. They connect through the strobes and buses on the core side.

The SPI pins are sampled by the block clock. SCK high and low phases must each last at least two block-clock cycles, and the pins must already be synchronous to that clock.

Top module: `spi_chan_regfile`

## Requirements
- R1: While `spi_cs_n` is low, the first 8 rising SCK edges shift the instruction in from `spi_mosi`, most significant bit first. Bits 7..4 are the channel number and bits 3..0 are the operation code.
- R2: Operation 4 takes a 16-bit field. It stores field bits 9..0 in the addressed channel's configuration (`rx_cfg[10*(n-1) +: 10]`) and pulses that channel's `rx_clear` bit for one cycle. For example, instruction 14h with 0232h sets channel 1 to 232h.
- R3: Operation 5 returns a 16-bit field holding the channel's configuration, with bits 15..10 read as 0. The field is sent MSB first, and its MSB appears on `spi_miso` after the SCK falling edge that follows the last instruction bit.
- R4: Operation 1 writes the 128-bit label table of the channel (first bit sent lands in bit 127 of `rx_labels[128*(n-1) +: 128]`). Operation 2 reads the table back in the same bit order.
- R5: Operation 3 returns the channel's 32-bit `rx_head` word, or all zeros when `rx_empty` is set. One `rx_pop` pulse follows chip-select release, and only when all 32 field bits were clocked and the FIFO is not empty.
- R6: Operation 6 returns 16 status bits. Bit k (k = 0..7) is `rx_empty` of channel k+1 and bit 8+k is `rx_full` of channel k+1. The channel nibble is ignored.
- R7: Operation 7 pulses `master_rst` for one cycle after the instruction. It has no data field, ignores the channel nibble, and leaves configurations and label tables unchanged.
- R8: Operations 8 and 9 load the 32-bit field into `tx_word` and pulse `tx_load`. `tx_slow` is set to 0 for operation 8 and to 1 for operation 9.
- R9: Operations 0 and A..F change no output. A channel-specific operation (1..5) addressed to channel 0 or to a channel above 8 also changes no output.
- R10: If `spi_cs_n` rises before a write field is complete, the partial write is discarded. The next transaction is decoded from a fresh instruction.
- R11: `spi_miso` is 0 while chip select is high and throughout write and no-data transactions.
- R12: Channel number n acts only on bit position n-1 of every per-channel vector, including channel 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| rx_empty | input | NCH | Per-channel FIFO empty flags |
| rx_full | input | NCH | Per-channel FIFO full flags |
| rx_head | input | NCH*32 | Per-channel FIFO head words |
| rx_pop | output | NCH | Per-channel FIFO pop strobe |
| rx_clear | output | NCH | Per-channel FIFO clear strobe |
| rx_cfg | output | NCH*10 | Per-channel stored configuration bits |
| rx_labels | output | NCH*128 | Per-channel label tables |
| master_rst | output | 1 | Master reset strobe for receive logic |
| tx_word | output | 32 | Transmit word |
| tx_load | output | 1 | Transmit load strobe |
| tx_slow | output | 1 | Transmit rate select, 1 = low speed |

## Verification
The hardest situation to reach is a transaction cut short. Chip select has to rise after only part of a write field or part of a FIFO read field. At that point the decoder must drop the partial write and withhold the pop, and the next full transaction must still decode. The bench's transfer task takes the number of field bits to clock as an argument, separate from the length the operation implies. It can therefore stop a 16-bit configuration write after 8 bits, or a 32-bit FIFO read after 16. A complete transaction then follows to show that the decoder recovered.

// File: rtl/spi_regfile_pkg.sv
// Package: shared constants and opcode helpers for the SPI channel register file.
// Assumes at most 15 channels (channel number fits the 4-bit nibble).
package spi_regfile_pkg;
    localparam int FIELD_MAX = 128;
    localparam int CNT_W     = 8;
    localparam int CFG_W     = 16;
    localparam int CFG_KEEP  = 10;
    localparam int LBL_W     = 128;
    localparam int WORD_W    = 32;

    localparam logic [3:0] OP_NOP    = 4'h0;
    localparam logic [3:0] OP_LBL_WR = 4'h1;
    localparam logic [3:0] OP_LBL_RD = 4'h2;
    localparam logic [3:0] OP_FIFO_RD= 4'h3;
    localparam logic [3:0] OP_CFG_WR = 4'h4;
    localparam logic [3:0] OP_CFG_RD = 4'h5;
    localparam logic [3:0] OP_STAT_RD= 4'h6;
    localparam logic [3:0] OP_MRST   = 4'h7;
    localparam logic [3:0] OP_TX_HI  = 4'h8;
    localparam logic [3:0] OP_TX_LO  = 4'h9;

    // Field length in bits for an operation; stat_len is the status width.
    function automatic logic [CNT_W-1:0] field_len(input logic [3:0] op,
                                                   input logic [CNT_W-1:0] stat_len);
        case (op)
            OP_LBL_WR, OP_LBL_RD: field_len = CNT_W'(LBL_W);
            OP_FIFO_RD:           field_len = CNT_W'(WORD_W);
            OP_CFG_WR, OP_CFG_RD: field_len = CNT_W'(CFG_W);
            OP_STAT_RD:           field_len = stat_len;
            OP_TX_HI, OP_TX_LO:   field_len = CNT_W'(WORD_W);
            default:              field_len = '0;
        endcase
    endfunction

    // True for operations that address one channel.
    function automatic logic chan_specific(input logic [3:0] op);
        chan_specific = (op >= OP_LBL_WR) && (op <= OP_CFG_RD);
    endfunction

    // True for operations whose field flows from block to host.
    function automatic logic is_read(input logic [3:0] op);
        is_read = (op == OP_LBL_RD) || (op == OP_FIFO_RD) ||
                  (op == OP_CFG_RD) || (op == OP_STAT_RD);
    endfunction

    // True for operations whose field flows from host to block.
    function automatic logic is_write(input logic [3:0] op);
        is_write = (op == OP_LBL_WR) || (op == OP_CFG_WR) ||
                   (op == OP_TX_HI)  || (op == OP_TX_LO);
    endfunction
endpackage

// File: rtl/spi_pin_sampler.sv
// Module: turns the SPI clock and select pins into single-cycle edge pulses.
// Assumes the pins are already synchronous to clk; SCK edges count only while
// chip select is low.
module spi_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_n_q;

    // Hold last-cycle pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sck_q  <= sck;
            cs_n_q <= cs_n;
        end
    end

    // Derive edge pulses from current and held levels.
    always_comb begin
        sck_rise = !cs_n && sck && !sck_q;
        sck_fall = !cs_n && !sck && sck_q;
        cs_rise  = cs_n && !cs_n_q;
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
// Module: SPI transaction sequencer. Shifts in the 8-bit instruction, resolves
// the operation and field length, then shifts the data field in (writes) or
// out (reads). Emits strobes for instruction done, write field done and a
// complete read at chip-select release.
// Assumes SCK high and low phases each last at least two clk cycles.
module spi_cmd_decoder
    import spi_regfile_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 si,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 cs_rise,
    input  logic [FIELD_MAX-1:0] rd_data,
    output logic [3:0]           op_q,
    output logic [3:0]           ch_q,
    output logic                 op_stb,
    output logic                 wr_stb,
    output logic [FIELD_MAX-1:0] wr_data,
    output logic                 fin_stb,
    output logic                 miso
);
    localparam logic [CNT_W-1:0] STAT_LEN = CNT_W'(2 * NCH);

    typedef enum logic [1:0] {ST_IDLE, ST_OPC, ST_DATA, ST_DONE} seq_t;

    seq_t                 st;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     len_q;
    logic [6:0]           op_sr;
    logic [FIELD_MAX-1:0] out_sr;

    logic [7:0]           opc_full;
    logic                 opc_bad;
    logic [3:0]           opc_eff;
    logic [CNT_W-1:0]     opc_len;

    // Resolve the instruction as it completes on the eighth rising edge.
    always_comb begin
        opc_full = {op_sr, si};
        opc_bad  = chan_specific(opc_full[3:0]) &&
                   ((opc_full[7:4] == 4'd0) || (int'(opc_full[7:4]) > NCH));
        opc_eff  = opc_bad ? OP_NOP : opc_full[3:0];
        opc_len  = field_len(opc_eff, STAT_LEN);
    end

    // Transaction state machine and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            len_q   <= '0;
            op_sr   <= '0;
            op_q    <= OP_NOP;
            ch_q    <= '0;
            op_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            fin_stb <= 1'b0;
            wr_data <= '0;
            out_sr  <= '0;
            miso    <= 1'b0;
        end else begin
            op_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            fin_stb <= 1'b0;
            if (op_stb) begin
                out_sr <= rd_data;
            end
            if (cs_n) begin
                if (cs_rise && st == ST_DONE && is_read(op_q)) begin
                    fin_stb <= 1'b1;
                end
                st   <= ST_IDLE;
                cnt  <= '0;
                miso <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE, ST_OPC: begin
                        if (sck_rise) begin
                            op_sr <= opc_full[6:0];
                            if (cnt == CNT_W'(7)) begin
                                op_q   <= opc_eff;
                                ch_q   <= opc_full[7:4];
                                len_q  <= opc_len;
                                cnt    <= '0;
                                op_stb <= 1'b1;
                                st     <= (opc_len == '0) ? ST_DONE : ST_DATA;
                            end else begin
                                cnt <= cnt + 1'b1;
                                st  <= ST_OPC;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (sck_fall) begin
                            miso   <= is_read(op_q) ? out_sr[FIELD_MAX-1] : 1'b0;
                            out_sr <= {out_sr[FIELD_MAX-2:0], 1'b0};
                        end
                        if (sck_rise) begin
                            wr_data <= {wr_data[FIELD_MAX-2:0], si};
                            cnt     <= cnt + 1'b1;
                            if (cnt == len_q - 1'b1) begin
                                st <= ST_DONE;
                                if (is_write(op_q)) begin
                                    wr_stb <= 1'b1;
                                end
                            end
                        end
                    end
                    default: begin
                        if (sck_fall) begin
                            miso <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // R1: instruction bit counter never passes the last opcode bit.
    assert_opc_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPC) |-> (cnt < CNT_W'(8)));

    // R11: data out stays low once chip select has been high for a cycle.
    assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);

    // R5: a completed read is reported only after chip select is released.
    assert_fin_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_stb |-> cs_n);

    // R10: a write strobe only follows a rising SCK edge inside a field.
    assert_write_needs_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sck_rise));
endmodule

// File: rtl/spi_chan_regs.sv
// Module: per-channel configuration and label storage, read-data mux, and the
// core-side strobes (FIFO pop and clear, master reset, transmit load).
// Assumes op/ch are stable from op_stb until the next transaction starts.
module spi_chan_regs
    import spi_regfile_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             op,
    input  logic [3:0]             ch,
    input  logic                   op_stb,
    input  logic                   wr_stb,
    input  logic [FIELD_MAX-1:0]   wr_data,
    input  logic                   fin_stb,
    input  logic [NCH-1:0]         rx_empty,
    input  logic [NCH-1:0]         rx_full,
    input  logic [NCH*WORD_W-1:0]  rx_head,
    output logic [FIELD_MAX-1:0]   rd_data,
    output logic [NCH-1:0]         rx_pop,
    output logic [NCH-1:0]         rx_clear,
    output logic [NCH*CFG_KEEP-1:0] rx_cfg,
    output logic [NCH*LBL_W-1:0]   rx_labels,
    output logic                   master_rst,
    output logic [WORD_W-1:0]      tx_word,
    output logic                   tx_load,
    output logic                   tx_slow
);
    localparam int STAT_W = 2 * NCH;

    logic [NCH-1:0]      ch_hit;
    logic [CFG_KEEP-1:0] sel_cfg;
    logic [LBL_W-1:0]    sel_lbl;
    logic [WORD_W-1:0]   sel_head;
    logic                sel_empty;

    // One-hot decode of the channel nibble (channel n drives bit n-1).
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_hit[i] = (ch == 4'(i + 1));
        end
    end

    // Per-channel storage, one copy per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Configuration register: write clears the channel FIFO.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_cfg[g*CFG_KEEP +: CFG_KEEP] <= '0;
                rx_clear[g]                    <= 1'b0;
            end else begin
                rx_clear[g] <= 1'b0;
                if (wr_stb && op == OP_CFG_WR && ch_hit[g]) begin
                    rx_cfg[g*CFG_KEEP +: CFG_KEEP] <= wr_data[CFG_KEEP-1:0];
                    rx_clear[g]                    <= 1'b1;
                end
            end
        end

        // Label table register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_labels[g*LBL_W +: LBL_W] <= '0;
            end else if (wr_stb && op == OP_LBL_WR && ch_hit[g]) begin
                rx_labels[g*LBL_W +: LBL_W] <= wr_data[LBL_W-1:0];
            end
        end
    end

    // Select the addressed channel's resources (OR mux over one-hot hit).
    always_comb begin
        sel_cfg   = '0;
        sel_lbl   = '0;
        sel_head  = '0;
        sel_empty = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                sel_cfg   = rx_cfg[i*CFG_KEEP +: CFG_KEEP];
                sel_lbl   = rx_labels[i*LBL_W +: LBL_W];
                sel_head  = rx_head[i*WORD_W +: WORD_W];
                sel_empty = rx_empty[i];
            end
        end
    end

    // Left-aligned read field for the decoder's output shifter.
    always_comb begin
        rd_data = '0;
        case (op)
            OP_LBL_RD:  rd_data[FIELD_MAX-1 -: LBL_W] = sel_lbl;
            OP_FIFO_RD: rd_data[FIELD_MAX-1 -: WORD_W] = sel_empty ? '0 : sel_head;
            OP_CFG_RD:  rd_data[FIELD_MAX-1 -: CFG_W] =
                            {{(CFG_W-CFG_KEEP){1'b0}}, sel_cfg};
            OP_STAT_RD: rd_data[FIELD_MAX-1 -: STAT_W] = {rx_full, rx_empty};
            default:    rd_data = '0;
        endcase
    end

    // FIFO pop after a complete read of a non-empty FIFO.
    always_comb begin
        rx_pop = (fin_stb && op == OP_FIFO_RD) ? (ch_hit & ~rx_empty) : '0;
    end

    // Global strobes: master reset and transmit word load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_rst <= 1'b0;
            tx_word    <= '0;
            tx_load    <= 1'b0;
            tx_slow    <= 1'b0;
        end else begin
            master_rst <= op_stb && (op == OP_MRST);
            tx_load    <= 1'b0;
            if (wr_stb && (op == OP_TX_HI || op == OP_TX_LO)) begin
                tx_word <= wr_data[WORD_W-1:0];
                tx_load <= 1'b1;
                tx_slow <= (op == OP_TX_LO);
            end
        end
    end

    // R2: a FIFO clear only follows a completed configuration write.
    assert_clear_after_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_clear) |-> ($past(wr_stb) && $past(op) == OP_CFG_WR));

    // R7: master reset never coincides with a store or transmit action.
    assert_mrst_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        master_rst |-> (!tx_load && rx_clear == '0));

    // R7: configuration is untouched in the cycle after master reset.
    assert_mrst_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        master_rst |=> $stable(rx_cfg));

    // R12: at most one channel pops at a time.
    assert_pop_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop));

    // R8: a transmit load follows a completed transmit write.
    assert_tx_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(wr_stb));
endmodule

// File: rtl/spi_chan_regfile.sv
// Module: top of the SPI instruction decoder and channel register file.
// Joins the pin sampler, the transaction sequencer and the channel registers.
// Assumes SPI pins synchronous to clk, SCK phases of two clk cycles or more.
module spi_chan_regfile
    import spi_regfile_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_cs_n,
    input  logic                    spi_sck,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    input  logic [NCH-1:0]          rx_empty,
    input  logic [NCH-1:0]          rx_full,
    input  logic [NCH*32-1:0]       rx_head,
    output logic [NCH-1:0]          rx_pop,
    output logic [NCH-1:0]          rx_clear,
    output logic [NCH*10-1:0]       rx_cfg,
    output logic [NCH*128-1:0]      rx_labels,
    output logic                    master_rst,
    output logic [31:0]             tx_word,
    output logic                    tx_load,
    output logic                    tx_slow
);
    logic                 sck_rise;
    logic                 sck_fall;
    logic                 cs_rise;
    logic [3:0]           op_q;
    logic [3:0]           ch_q;
    logic                 op_stb;
    logic                 wr_stb;
    logic                 fin_stb;
    logic [FIELD_MAX-1:0] wr_data;
    logic [FIELD_MAX-1:0] rd_data;

    spi_pin_sampler u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    spi_cmd_decoder #(.NCH(NCH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .si       (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .rd_data  (rd_data),
        .op_q     (op_q),
        .ch_q     (ch_q),
        .op_stb   (op_stb),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .fin_stb  (fin_stb),
        .miso     (spi_miso)
    );

    spi_chan_regs #(.NCH(NCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op_q),
        .ch         (ch_q),
        .op_stb     (op_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .fin_stb    (fin_stb),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .rx_head    (rx_head),
        .rd_data    (rd_data),
        .rx_pop     (rx_pop),
        .rx_clear   (rx_clear),
        .rx_cfg     (rx_cfg),
        .rx_labels  (rx_labels),
        .master_rst (master_rst),
        .tx_word    (tx_word),
        .tx_load    (tx_load),
        .tx_slow    (tx_slow)
    );
endmodule

// File: tb/sim_spi_chan_regfile.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_spi_chan_regfile;
    localparam int NCH = 8;
    localparam int HALF = 4;   // clk cycles per SCK phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    logic [NCH-1:0] rx_empty = '1, rx_full = '0;
    logic [NCH*32-1:0] rx_head = '0;
    logic [NCH-1:0] rx_pop, rx_clear;
    logic [NCH*10-1:0] rx_cfg;
    logic [NCH*128-1:0] rx_labels;
    logic master_rst, tx_load, tx_slow;
    logic [31:0] tx_word;

    int errors = 0, checks = 0;
    int pop_cnt [NCH];
    int clr_cnt [NCH];
    int mrst_cnt, txl_cnt;
    logic mon_clr = 1'b0;
    logic miso_seen;
    logic done = 1'b0;

    localparam logic [127:0] LBL_PAT = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

    always #2 clk = ~clk;   // 250 MHz

    spi_chan_regfile #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .rx_empty(rx_empty),
        .rx_full(rx_full), .rx_head(rx_head), .rx_pop(rx_pop),
        .rx_clear(rx_clear), .rx_cfg(rx_cfg), .rx_labels(rx_labels),
        .master_rst(master_rst), .tx_word(tx_word), .tx_load(tx_load),
        .tx_slow(tx_slow)
    );

    // Pulse monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < NCH; i++) begin pop_cnt[i] = 0; clr_cnt[i] = 0; end
            mrst_cnt = 0; txl_cnt = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rx_pop[i]) pop_cnt[i]++;
                if (rx_clear[i]) clr_cnt[i]++;
            end
            if (master_rst) mrst_cnt++;
            if (tx_load) txl_cnt++;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    // One transaction: opcode then nbits of field (wdata left-aligned).
    task automatic xfer(input logic [7:0] opc, input int nbits,
                        input logic [127:0] wdata, output logic [127:0] rdata);
        rdata = '0;
        miso_seen = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 8 + nbits; i++) begin
            mosi = (i < 8) ? opc[7 - i] : wdata[127 - (i - 8)];
            repeat (HALF) @(negedge clk);
            if (i >= 8) rdata[127 - (i - 8)] = miso;
            if (miso) miso_seen = 1'b1;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (miso) miso_seen = 1'b1;
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic logic [9:0] cfg_of(input int n);
        return rx_cfg[(n-1)*10 +: 10];
    endfunction

    task automatic t_reset();
        check("R11 miso idle at reset", 128'(miso), 128'(0));
        check("R2 cfg zero at reset", 128'(rx_cfg), 128'(0));
        check("R8 tx_load idle at reset", 128'(tx_load), 128'(0));
    endtask

    task automatic t_cfg_write();
        logic [127:0] r;
        clear_mon();
        xfer(8'h14, 16, {16'h0232, 112'b0}, r);
        check("R2 R1 cfg ch1 from 14h/0232h", 128'(cfg_of(1)), 128'h232);
        check("R2 clear pulse ch1", 128'(clr_cnt[0]), 128'(1));
        check("R12 no clear on ch2", 128'(clr_cnt[1]), 128'(0));
        check("R11 miso low during write", 128'(miso_seen), 128'(0));
        clear_mon();
        xfer(8'h84, 16, {16'h0155, 112'b0}, r);
        check("R12 cfg ch8", 128'(cfg_of(8)), 128'h155);
        check("R12 clear pulse ch8", 128'(clr_cnt[7]), 128'(1));
    endtask

    task automatic t_cfg_read();
        logic [127:0] r;
        xfer(8'h34, 16, {16'hFFFF, 112'b0}, r);
        check("R2 cfg ch3 keeps bits 9..0", 128'(cfg_of(3)), 128'h3FF);
        xfer(8'h35, 16, '0, r);
        check("R3 cfg ch3 readback upper zero", 128'(r[127:112]), 128'h03FF);
    endtask

    task automatic t_labels();
        logic [127:0] r;
        xfer(8'h21, 128, LBL_PAT, r);
        check("R4 label table ch2 stored", rx_labels[128 +: 128], LBL_PAT);
        xfer(8'h22, 128, '0, r);
        check("R4 label readback ch2", r, LBL_PAT);
    endtask

    task automatic t_fifo();
        logic [127:0] r;
        rx_head[4*32 +: 32] = 32'hA5A5_1234;
        rx_empty[4] = 1'b0;
        clear_mon();
        xfer(8'h53, 32, '0, r);
        check("R5 fifo head ch5", 128'(r[127:96]), 128'hA5A5_1234);
        check("R5 one pop ch5", 128'(pop_cnt[4]), 128'(1));
        check("R12 no pop ch4", 128'(pop_cnt[3]), 128'(0));
        clear_mon();
        xfer(8'h53, 16, '0, r);
        check("R5 R10 no pop on short read", 128'(pop_cnt[4]), 128'(0));
        rx_empty[4] = 1'b1;
        clear_mon();
        xfer(8'h53, 32, '0, r);
        check("R5 empty fifo reads zero", 128'(r[127:96]), 128'(0));
        check("R5 no pop when empty", 128'(pop_cnt[4]), 128'(0));
    endtask

    task automatic t_status();
        logic [127:0] r;
        rx_empty = 8'hA5;
        rx_full  = 8'h42;
        xfer(8'hF6, 16, '0, r);
        check("R6 status word", 128'(r[127:112]), 128'h42A5);
        rx_empty = '1;
        rx_full  = '0;
    endtask

    task automatic t_mrst();
        logic [127:0] r;
        clear_mon();
        xfer(8'h07, 0, '0, r);
        check("R7 master reset pulse", 128'(mrst_cnt), 128'(1));
        check("R7 cfg ch1 kept", 128'(cfg_of(1)), 128'h232);
        check("R7 labels ch2 kept", rx_labels[128 +: 128], LBL_PAT);
    endtask

    task automatic t_tx();
        logic [127:0] r;
        clear_mon();
        xfer(8'h08, 32, {32'hDEAD_BEEF, 96'b0}, r);
        check("R8 tx word high speed", 128'(tx_word), 128'hDEAD_BEEF);
        check("R8 tx rate high", 128'(tx_slow), 128'(0));
        xfer(8'h39, 32, {32'h1234_5678, 96'b0}, r);
        check("R8 tx word low speed", 128'(tx_word), 128'h1234_5678);
        check("R8 tx rate low", 128'(tx_slow), 128'(1));
        check("R8 two loads", 128'(txl_cnt), 128'(2));
    endtask

    task automatic t_noop();
        logic [127:0] r;
        logic [NCH*10-1:0] cfg_before;
        cfg_before = rx_cfg;
        clear_mon();
        xfer(8'h1A, 16, {16'hFFFF, 112'b0}, r);
        xfer(8'h00, 16, {16'hFFFF, 112'b0}, r);
        xfer(8'h94, 16, {16'h0155, 112'b0}, r);
        xfer(8'h04, 16, {16'h0155, 112'b0}, r);
        check("R9 cfg unchanged by noops", 128'(rx_cfg), 128'(cfg_before));
        check("R9 no clears by noops", 128'(clr_cnt[0] + clr_cnt[7]), 128'(0));
        check("R9 no strobes by noops", 128'(mrst_cnt + txl_cnt), 128'(0));
        check("R11 miso low for noop", 128'(miso_seen), 128'(0));
    endtask

    task automatic t_abort();
        logic [127:0] r;
        clear_mon();
        xfer(8'h14, 8, {16'hFFFF, 112'b0}, r);
        check("R10 partial write dropped", 128'(cfg_of(1)), 128'h232);
        check("R10 no clear on partial", 128'(clr_cnt[0]), 128'(0));
        xfer(8'h14, 16, {16'h0011, 112'b0}, r);
        check("R10 next write decodes", 128'(cfg_of(1)), 128'h011);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cfg_write();
        t_cfg_read();
        t_labels();
        t_fifo();
        t_status();
        t_mrst();
        t_tx();
        t_noop();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule